// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer. Every input clock cycle counts. A digital model of a dual-modulus prescaler divides the input by P or by P+1. A main counter and a swallow counter sit behind the prescaler and steer its modulus. Together they produce one output pulse every N = B·P + A input cycles. B is a 13-bit main count, A is a 6-bit swallow count, and P is picked from four prescaler pairs.

The modulus-control line requests P+1 for the first A prescaler periods of each division cycle and P for the rest. This lets odd ratios be reached while only the prescaler steps at the full input rate. The main count, the swallow count and the prescaler select are sampled at the start of every division cycle, so changing them mid-cycle is safe. A synchronous counter-reset input holds all counters at their load state, which lets the divider restart in step with a reference divider. The block carries no data stream. Every pin is a plain level or pulse, with no handshake and no back-pressure.

Top module: `pswallow_div`

## Requirements
- R1: With a steady configuration, `div_out` rises once every N = B·P + A input cycles.
- R2: `pre_sel` picks P as follows: 0 gives P=8, 1 gives 16, 2 gives 32, 3 gives 64. The prescaler then divides by P or P+1.
- R3: `mod_ctl` is high while the swallow count of the current division cycle is non-zero. Over one division cycle it is high for exactly A·(P+1) input cycles, and once low it stays low until the next reload.
- R4: `div_out` stays high for the final prescaler period of each division cycle. That is P cycles, or P+1 cycles when A equals B.
- R5: While `cnt_rst` is 1, `div_out` is 0 and `mod_ctl` equals (A != 0). Counting starts on the first edge with `cnt_rst` at 0. `div_out` first reads 1 after N − P − (A==B ? 1 : 0) such edges.
- R6: A, B and `pre_sel` are sampled only at the start of a division cycle. A change made while a cycle runs first takes effect in the next cycle.
- R7: `cfg_err` is 1, in the same cycle, whenever `main_val` < 3 or `main_val` < `swallow_val`, and is 0 otherwise.
- R8: A synchronous low `rst_n` drives `div_out` and `mod_ctl` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_rst | input | 1 | Hold all counters at their load state |
| swallow_val | input | 6 | Programmed swallow count A (0..63) |
| main_val | input | 13 | Programmed main count B (3..8191) |
| pre_sel | input | 2 | Prescaler pair select |
| div_out | output | 1 | Divided output pulse |
| mod_ctl | output | 1 | 1 requests P+1, 0 requests P |
| cfg_err | output | 1 | Configuration violates B ≥ 3 or B ≥ A |

## Verification
`cfg_err` is combinational, so it is checked a fraction of a cycle after its inputs change. `div_out` and `mod_ctl` come from registers and change on the edge that ends a prescaler period. The bench counts every rising edge after `cnt_rst` is released and samples on the following falling edge. It then compares the edge index of the first rise, the spacing between rises, the pulse width and the number of `mod_ctl`-high samples in one rise-to-rise window against values computed from A, B and P. For the mid-cycle change, the expected spacing is the rest of the old last period plus the new cycle up to its own last period.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  // Smallest prescaler modulus; each select step doubles it.
  localparam int unsigned PRE_BASE = 8;

  function automatic int unsigned pre_modulus(input int unsigned base, input int unsigned sel);
    return base << sel;
  endfunction
endpackage

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
  parameter int PCW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [PCW-1:0] p_val,
  input  logic           mc,
  output logic           tick
);
  logic [PCW-1:0] pc;
  logic [PCW-1:0] last_idx;

  // A period is P cycles, or P+1 cycles while the modulus control requests it.
  assign last_idx = p_val - PCW'(1) + PCW'(mc);
  assign tick     = !clr && (pc == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n)          pc <= '0;
    else if (clr || tick) pc <= '0;
    else                 pc <= pc + PCW'(1);
  end
endmodule

// File: rtl/pswallow_main_ctr.sv
module pswallow_main_ctr #(
  parameter int BW = 13,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          tick,
  input  logic [BW-1:0] b_in,
  input  logic [SW-1:0] sel_in,
  output logic [SW-1:0] sel_q,
  output logic          at_term,
  output logic          wrap
);
  logic [BW-1:0] b_cnt;

  assign at_term = (b_cnt == BW'(1));
  assign wrap    = tick && (b_cnt <= BW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_cnt <= '0;
      sel_q <= '0;
    end else if (hold || wrap) begin
      b_cnt <= b_in;
      sel_q <= sel_in;
    end else if (tick) begin
      b_cnt <= b_cnt - BW'(1);
    end
  end
endmodule

// File: rtl/pswallow_swallow_ctr.sv
module pswallow_swallow_ctr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          tick,
  input  logic [AW-1:0] a_in,
  output logic          mc
);
  logic [AW-1:0] a_cnt;

  assign mc = (a_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)              a_cnt <= '0;
    else if (load)           a_cnt <= a_in;
    else if (tick && mc)     a_cnt <= a_cnt - AW'(1);
  end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int AW    = 6,
  parameter int BW    = 13,
  parameter int SW    = 2,
  parameter int PBASE = pswallow_pkg::PRE_BASE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_rst,
  input  logic [AW-1:0] swallow_val,
  input  logic [BW-1:0] main_val,
  input  logic [SW-1:0] pre_sel,
  output logic          div_out,
  output logic          mod_ctl,
  output logic          cfg_err
);
  localparam int NSEL = 2 ** SW;
  localparam int PMAX = PBASE << (NSEL - 1);
  localparam int PCW  = $clog2(PMAX + 2);

  logic [PCW-1:0] p_tab [NSEL];
  logic [SW-1:0]  sel_q;
  logic [PCW-1:0] p_val;
  logic           tick;
  logic           wrap;
  logic           at_term;

  genvar g;
  generate
    for (g = 0; g < NSEL; g++) begin : g_mod
      assign p_tab[g] = PCW'(pswallow_pkg::pre_modulus(PBASE, g));
    end
  endgenerate

  assign p_val = p_tab[sel_q];

  pswallow_prescaler #(.PCW(PCW)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(cnt_rst),
    .p_val(p_val), .mc(mod_ctl), .tick(tick)
  );

  pswallow_main_ctr #(.BW(BW), .SW(SW)) u_main (
    .clk(clk), .rst_n(rst_n), .hold(cnt_rst), .tick(tick),
    .b_in(main_val), .sel_in(pre_sel), .sel_q(sel_q),
    .at_term(at_term), .wrap(wrap)
  );

  pswallow_swallow_ctr #(.AW(AW)) u_swal (
    .clk(clk), .rst_n(rst_n), .load(cnt_rst || wrap), .tick(tick),
    .a_in(swallow_val), .mc(mod_ctl)
  );

  assign div_out = at_term;
  assign cfg_err = (main_val < BW'(3)) || (main_val < {{(BW-AW){1'b0}}, swallow_val});
endmodule

// File: rtl/pswallow_chk.sv
module pswallow_chk #(
  parameter int WMAX = 65
) (
  input logic clk,
  input logic rst_n,
  input logic cnt_rst,
  input logic div_out,
  input logic mod_ctl,
  input logic cfg_err
);
  logic [7:0] hi_cnt;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      seen   <= 1'b0;
    end else begin
      hi_cnt <= div_out ? ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1) : 8'd0;
      if (cnt_rst || (!div_out && hi_cnt != 8'd0)) seen <= 1'b1;
    end
  end

  // R5
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rst && !cfg_err) |=> !div_out);

  // R3
  mc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(mod_ctl)) |-> ($fell(div_out) || cnt_rst || $past(cnt_rst)));

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> (hi_cnt < 8'(WMAX)));

  // R1
  pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_out) |=> !div_out);
endmodule

bind pswallow_div pswallow_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst),
  .div_out(div_out), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
);

// File: tb/tb_pswallow_div.sv
module tb_pswallow_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_rst = 1'b1;
  logic [5:0]  swallow_val = '0;
  logic [12:0] main_val = 13'd3;
  logic [1:0]  pre_sel = '0;
  logic        div_out, mod_ctl, cfg_err;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pswallow_div dut (
    .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .swallow_val(swallow_val),
    .main_val(main_val), .pre_sel(pre_sel), .div_out(div_out),
    .mod_ctl(mod_ctl), .cfg_err(cfg_err)
  );

  function automatic int p_of(input int sel); return 8 << sel; endfunction
  function automatic int n_of(input int a, b, sel); return b * p_of(sel) + a; endfunction
  function automatic int last_of(input int a, b, sel); return p_of(sel) + ((a == b) ? 1 : 0); endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_cfg(input int a, b, sel, input bit sw, input int a2, b2, sel2);
    int n, lst, r, r1, r2, r3, w, mcc;
    bit prev, cur;
    @(negedge clk);
    swallow_val = 6'(a); main_val = 13'(b); pre_sel = 2'(sel); cnt_rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(div_out == 1'b0, "R5 hold out", int'(div_out), 0);
    chk(mod_ctl == (a != 0), "R5 hold mod_ctl", int'(mod_ctl), int'(a != 0));
    cnt_rst = 1'b0;
    n = n_of(a, b, sel); lst = last_of(a, b, sel);
    r = 0; r1 = 0; r2 = 0; r3 = 0; w = -1; mcc = 0; prev = 1'b0;
    for (int k = 1; k <= 4 * n + 300 && r < (sw ? 2 : 3); k++) begin
      @(negedge clk);
      cur = div_out;
      if (cur && !prev) begin
        r++;
        if (r == 1) r1 = k; else if (r == 2) r2 = k; else r3 = k;
        if (sw && r == 1) begin
          swallow_val = 6'(a2); main_val = 13'(b2); pre_sel = 2'(sel2);
        end
      end
      if (r == 1 && mod_ctl) mcc++;
      if (r == 1 && w < 0 && !cur && prev) w = k - r1;
      prev = cur;
    end
    chk(r1 == n - lst, "R5 first pulse", r1, n - lst);
    chk(w == lst, "R4 pulse width", w, lst);
    if (sw) begin
      int e;
      e = lst + n_of(a2, b2, sel2) - last_of(a2, b2, sel2);
      chk(r2 - r1 == e, "R6 mid-cycle change", r2 - r1, e);
    end else begin
      chk(r2 - r1 == n, "R1 R2 ratio first", r2 - r1, n);
      chk(r3 - r2 == n, "R1 R2 ratio second", r3 - r2, n);
      chk(mcc == a * (p_of(sel) + 1), "R3 mod_ctl cycles", mcc, a * (p_of(sel) + 1));
    end
  endtask

  task automatic err_case(input int a, b);
    bit e;
    @(negedge clk);
    cnt_rst = 1'b1; swallow_val = 6'(a); main_val = 13'(b);
    #1;
    e = (b < 3) || (b < a);
    chk(cfg_err == e, "R7 cfg_err", int'(cfg_err), int'(e));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    cnt_rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(div_out == 1'b0, "R8 reset out", int'(div_out), 0);
    chk(mod_ctl == 1'b0, "R8 reset mod_ctl", int'(mod_ctl), 0);
    rst_n = 1'b1;

    err_case(0, 2);
    err_case(5, 4);
    err_case(3, 3);
    err_case(63, 8191);
    err_case(0, 3);

    run_cfg(0, 3, 0, 1'b0, 0, 0, 0);
    run_cfg(3, 3, 0, 1'b0, 0, 0, 0);
    run_cfg(5, 7, 1, 1'b0, 0, 0, 0);
    run_cfg(4, 4, 2, 1'b0, 0, 0, 0);
    run_cfg(0, 3, 3, 1'b0, 0, 0, 0);
    run_cfg(63, 63, 3, 1'b0, 0, 0, 0);
    run_cfg(2, 5, 0, 1'b1, 6, 9, 1);

    for (int i = 0; i < 10; i++) begin
      int b, a, s;
      s = int'($urandom_range(1, 0));
      b = int'($urandom_range(40, 3));
      a = int'($urandom_range(b, 0));
      run_cfg(a, b, s, 1'b0, 0, 0, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule